// File: doc/BRIEF.md
# Dithered PWM Dimming Modulator

This block drives a single dimming output from a 16-bit brightness word. A short up-counting PWM core of selectable width (1 to 12 bits) sets the base pulse. A first-order delta-sigma accumulator of selectable width (0 to 4 bits) decides, period by period, whether the pulse is one clock longer than the base. Over one dither cycle of 2^D PWM periods, the average duty therefore has P+D bits of resolution, where P is the PWM width and D is the delta-sigma width.

The output repeat rate follows from the clock and the two widths. A PWM period lasts 2^P clocks and a dither cycle lasts 2^(P+D) clocks. A wide accumulator and a narrow counter give a fast base frequency with slow dither, and the reverse gives a slow base frequency with less dither. The brightness word and both width selections are captured only when a dither cycle starts, so that every cycle delivers its exact average.

Top module: `dith_pwm_mod`

## Requirements
- R1: While reset is asserted (rst_n low), and afterwards while run is low, dim_out is 0.
- R2: When run is sampled low at a clock edge, dim_out is 0 after that edge, and the modulator returns to idle. The next rise of run starts a fresh dither cycle with a cleared accumulator.
- R3: While running, each PWM period lasts exactly 2^P clocks. Within a period the output is high for a single contiguous run that starts at the period's first clock.
- R4: The effective code is the low P+D bits of level; the bits above them are ignored. The base count is code >> D and the fraction is the low D bits of code.
- R5: Each period's high time is base + c. Here c is the carry out of a D-bit accumulator that starts at 0 on a fresh start and adds the fraction once at the start of every period.
- R6: Over each dither cycle of 2^D periods, the total high time equals the effective code exactly, and the accumulator returns to 0.
- R7: Changes to level, pwm_sel or dsm_sel during a dither cycle have no effect until the next dither cycle starts.
- R8: pwm_sel of 0 acts as width 1, and values above 12 act as 12. dsm_sel values above 4 act as 4.
- R9: With D = 0 the output is a plain PWM. Every period has high time equal to code, and a new level takes effect at each period start.
- R10: When the base is 2^P - 1 and a carry occurs, the output stays high for the whole period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enable; low forces idle and a low output |
| level | input | 16 | Brightness word |
| pwm_sel | input | 4 | Requested PWM counter width in bits |
| dsm_sel | input | 3 | Requested delta-sigma accumulator width in bits |
| dim_out | output | 1 | Registered modulated output |

## Verification
The assertions assume that run, level and both width selections are synchronous to clk. They also assume that the widths seen by the core are the clamped values, so the accumulator never holds bits above the selected width. The stimulus changes every input only at falling edges. It sweeps small PWM widths against every accumulator width. It changes level only in the middle of a dither cycle, or while idle, so that the capture boundary is observable. Out-of-range selections are applied only in dedicated clamp cases.

// File: rtl/dm_pkg.sv
package dm_pkg;
    parameter int PWM_MAX_W = 12;
    parameter int DSM_MAX_W = 4;
    parameter int LVL_W     = PWM_MAX_W + DSM_MAX_W;
    parameter int PSEL_W    = $clog2(PWM_MAX_W + 1);
    parameter int DSEL_W    = $clog2(DSM_MAX_W + 1);

    // last counter value of a period for a given counter width
    function automatic logic [PWM_MAX_W-1:0] cnt_last(input logic [PSEL_W-1:0] pw);
        logic [PWM_MAX_W:0] t;
        t = ({{PWM_MAX_W{1'b0}}, 1'b1} << pw) - 1'b1;
        return t[PWM_MAX_W-1:0];
    endfunction

    // mask of the accumulator bits in use, also the last period index
    function automatic logic [DSM_MAX_W-1:0] dsm_mask(input logic [DSEL_W-1:0] dw);
        logic [DSM_MAX_W:0] t;
        t = ({{DSM_MAX_W{1'b0}}, 1'b1} << dw) - 1'b1;
        return t[DSM_MAX_W-1:0];
    endfunction
endpackage

// File: rtl/dm_width_sel.sv
module dm_width_sel #(
    parameter int PWM_MAX_W = dm_pkg::PWM_MAX_W,
    parameter int DSM_MAX_W = dm_pkg::DSM_MAX_W,
    parameter int PSEL_W    = dm_pkg::PSEL_W,
    parameter int DSEL_W    = dm_pkg::DSEL_W
) (
    input  logic [PSEL_W-1:0] pwm_sel_i,
    input  logic [DSEL_W-1:0] dsm_sel_i,
    output logic [PSEL_W-1:0] pw_o,
    output logic [DSEL_W-1:0] dw_o
);
    localparam logic [PSEL_W-1:0] PW_TOP = PSEL_W'(PWM_MAX_W);
    localparam logic [DSEL_W-1:0] DW_TOP = DSEL_W'(DSM_MAX_W);

    always_comb begin
        if (pwm_sel_i == '0) begin
            pw_o = PSEL_W'(1);
        end else if (pwm_sel_i > PW_TOP) begin
            pw_o = PW_TOP;
        end else begin
            pw_o = pwm_sel_i;
        end
        dw_o = (dsm_sel_i > DW_TOP) ? DW_TOP : dsm_sel_i;
    end
endmodule

// File: rtl/dm_code_split.sv
module dm_code_split #(
    parameter int PWM_MAX_W = dm_pkg::PWM_MAX_W,
    parameter int DSM_MAX_W = dm_pkg::DSM_MAX_W,
    parameter int LVL_W     = dm_pkg::LVL_W,
    parameter int PSEL_W    = dm_pkg::PSEL_W,
    parameter int DSEL_W    = dm_pkg::DSEL_W
) (
    input  logic [LVL_W-1:0]     level_i,
    input  logic [PSEL_W-1:0]    pw_i,
    input  logic [DSEL_W-1:0]    dw_i,
    output logic [PWM_MAX_W-1:0] base_o,
    output logic [DSM_MAX_W-1:0] frac_o
);
    localparam int TW = PSEL_W + 1;

    logic [TW-1:0]    tot_w;
    logic [LVL_W:0]   keep;
    logic [LVL_W-1:0] code;
    logic [LVL_W-1:0] upper;

    always_comb begin
        tot_w  = TW'(pw_i) + TW'(dw_i);
        keep   = ({{LVL_W{1'b0}}, 1'b1} << tot_w) - 1'b1;
        code   = level_i & keep[LVL_W-1:0];
        upper  = code >> dw_i;
        base_o = upper[PWM_MAX_W-1:0];
        frac_o = code[DSM_MAX_W-1:0] & dm_pkg::dsm_mask(dw_i);
    end
endmodule

// File: rtl/dm_sigma_step.sv
module dm_sigma_step #(
    parameter int DSM_MAX_W = dm_pkg::DSM_MAX_W,
    parameter int DSEL_W    = dm_pkg::DSEL_W
) (
    input  logic [DSM_MAX_W-1:0] acc_i,
    input  logic [DSM_MAX_W-1:0] frac_i,
    input  logic [DSEL_W-1:0]    dw_i,
    output logic                 carry_o,
    output logic [DSM_MAX_W-1:0] acc_o
);
    logic [DSM_MAX_W:0] sum;

    always_comb begin
        sum     = {1'b0, acc_i} + {1'b0, frac_i};
        carry_o = sum[dw_i];
        acc_o   = sum[DSM_MAX_W-1:0] & dm_pkg::dsm_mask(dw_i);
    end
endmodule

// File: rtl/dith_pwm_mod.sv
module dith_pwm_mod #(
    parameter int PWM_MAX_W = dm_pkg::PWM_MAX_W,
    parameter int DSM_MAX_W = dm_pkg::DSM_MAX_W,
    parameter int LVL_W     = dm_pkg::LVL_W,
    parameter int PSEL_W    = dm_pkg::PSEL_W,
    parameter int DSEL_W    = dm_pkg::DSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [LVL_W-1:0]  level,
    input  logic [PSEL_W-1:0] pwm_sel,
    input  logic [DSEL_W-1:0] dsm_sel,
    output logic              dim_out
);
    localparam int DUTY_W = PWM_MAX_W + 1;

    typedef struct packed {
        logic                 run;
        logic [PWM_MAX_W-1:0] cnt;
        logic [DSM_MAX_W-1:0] per;
        logic [DSM_MAX_W-1:0] acc;
        logic [DUTY_W-1:0]    duty;
        logic [LVL_W-1:0]     code;
        logic [PSEL_W-1:0]    pw;
        logic [DSEL_W-1:0]    dw;
        logic                 out;
    } mod_state_t;

    mod_state_t state_d, state_q;

    logic [PSEL_W-1:0]    pw_new;
    logic [DSEL_W-1:0]    dw_new;
    logic [PWM_MAX_W-1:0] last_q;
    logic [DSM_MAX_W-1:0] per_last_q;
    logic                 period_end;
    logic                 load;
    logic                 enter;
    logic [LVL_W-1:0]     cur_level;
    logic [PSEL_W-1:0]    cur_pw;
    logic [DSEL_W-1:0]    cur_dw;
    logic [PWM_MAX_W-1:0] base;
    logic [DSM_MAX_W-1:0] frac;
    logic                 carry;
    logic [DSM_MAX_W-1:0] acc_nx;

    dm_width_sel #(
        .PWM_MAX_W(PWM_MAX_W), .DSM_MAX_W(DSM_MAX_W),
        .PSEL_W(PSEL_W), .DSEL_W(DSEL_W)
    ) i_width_sel (
        .pwm_sel_i(pwm_sel),
        .dsm_sel_i(dsm_sel),
        .pw_o     (pw_new),
        .dw_o     (dw_new)
    );

    always_comb begin
        last_q     = dm_pkg::cnt_last(state_q.pw);
        per_last_q = dm_pkg::dsm_mask(state_q.dw);
        period_end = state_q.run && (state_q.cnt == last_q);
        load       = !state_q.run || (period_end && (state_q.per == per_last_q));
        enter      = !state_q.run || period_end;
        cur_level  = load ? level  : state_q.code;
        cur_pw     = load ? pw_new : state_q.pw;
        cur_dw     = load ? dw_new : state_q.dw;
    end

    dm_code_split #(
        .PWM_MAX_W(PWM_MAX_W), .DSM_MAX_W(DSM_MAX_W), .LVL_W(LVL_W),
        .PSEL_W(PSEL_W), .DSEL_W(DSEL_W)
    ) i_code_split (
        .level_i(cur_level),
        .pw_i   (cur_pw),
        .dw_i   (cur_dw),
        .base_o (base),
        .frac_o (frac)
    );

    dm_sigma_step #(
        .DSM_MAX_W(DSM_MAX_W), .DSEL_W(DSEL_W)
    ) i_sigma_step (
        .acc_i  (state_q.acc),
        .frac_i (frac),
        .dw_i   (cur_dw),
        .carry_o(carry),
        .acc_o  (acc_nx)
    );

    always_comb begin
        state_d = state_q;
        if (!run) begin
            state_d = '0;
        end else begin
            state_d.run  = 1'b1;
            state_d.code = cur_level;
            state_d.pw   = cur_pw;
            state_d.dw   = cur_dw;
            if (enter) begin
                state_d.cnt  = '0;
                state_d.per  = load ? '0 : state_q.per + 1'b1;
                state_d.duty = {1'b0, base} + DUTY_W'(carry);
                state_d.acc  = acc_nx;
            end else begin
                state_d.cnt  = state_q.cnt + 1'b1;
            end
            state_d.out = ({1'b0, state_d.cnt} < state_d.duty);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign dim_out = state_q.out;

    AST_RUN_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !dim_out); // R2

    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.run |-> (state_q.cnt <= dm_pkg::cnt_last(state_q.pw))); // R3

    AST_DUTY_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.run |-> (state_q.duty <= ({1'b0, dm_pkg::cnt_last(state_q.pw)} + 1'b1))); // R10

    AST_ACC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.run |-> ((state_q.acc & ~dm_pkg::dsm_mask(state_q.dw)) == '0)); // R5

    AST_ACC_EMPTY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.run && state_q.cnt == dm_pkg::cnt_last(state_q.pw)
         && state_q.per == dm_pkg::dsm_mask(state_q.dw)) |-> (state_q.acc == '0)); // R6

    AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.run && $past(state_q.run) && !(state_q.cnt == '0 && state_q.per == '0))
        |-> ($stable(state_q.code) && $stable(state_q.pw) && $stable(state_q.dw))); // R7
endmodule

// File: tb/test_dith_pwm_mod.sv
module test_dith_pwm_mod;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [15:0] level = '0;
    logic [3:0]  pwm_sel = 4'd1;
    logic [2:0]  dsm_sel = 3'd0;
    logic        dim_out;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    dith_pwm_mod i_dith_pwm_mod (
        .clk(clk), .rst_n(rst_n), .run(run), .level(level),
        .pwm_sel(pwm_sel), .dsm_sel(dsm_sel), .dim_out(dim_out)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<190000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Samples one dither cycle, comparing every clock with the arithmetic model.
    // When chg_en is set, level is changed to chg_lvl halfway through.
    task automatic one_cycle(input int P, input int D, input int code,
                             input bit chg_en, input logic [15:0] chg_lvl,
                             output int mism, output int hi_sum, output int per_bad);
        int acc;
        int n;
        int idx;
        acc = 0; mism = 0; hi_sum = 0; per_bad = 0; idx = 0;
        n = 1 << (P + D);
        for (int k = 0; k < (1 << D); k++) begin
            int s;
            int c;
            int duty;
            int hi;
            s = acc + (code & ((1 << D) - 1));
            c = s >> D;
            acc = s & ((1 << D) - 1);
            duty = (code >> D) + c;
            hi = 0;
            for (int i = 0; i < (1 << P); i++) begin
                bit e;
                e = (i < duty);
                @(negedge clk);
                if (dim_out !== e) mism = mism + 1;
                if (dim_out === 1'b1) hi = hi + 1;
                idx = idx + 1;
                if (chg_en && idx == n / 2) level = chg_lvl;
            end
            hi_sum = hi_sum + hi;
            if (hi != (code >> D) && hi != (code >> D) + 1) per_bad = per_bad + 1;
        end
    endtask

    task automatic run_case(input int psel, input int dsel, input int code1, input int code2,
                            input string tag);
        int P;
        int D;
        int m;
        int hs;
        int pb;
        logic [15:0] junk;
        logic [15:0] lv1;
        logic [15:0] lv2;
        P = (psel == 0) ? 1 : ((psel > 12) ? 12 : psel);
        D = (dsel > 4) ? 4 : dsel;
        junk = 16'hB6D5 & ~16'((32'd1 << (P + D)) - 1);
        lv1 = junk | 16'(code1);
        lv2 = ~junk & ~16'((32'd1 << (P + D)) - 1) | 16'(code2);
        @(negedge clk);
        pwm_sel = 4'(psel);
        dsm_sel = 3'(dsel);
        level = lv1;
        run = 1'b1;
        @(posedge clk);
        one_cycle(P, D, code1, 1'b1, lv2, m, hs, pb);
        chk(m == 0, {tag, " R3 R4 R5 first cycle pattern mismatches"}, m, 0);
        chk(hs == code1, {tag, " R6 first cycle high total"}, hs, code1);
        chk(pb == 0, {tag, " R5 periods off by more than one"}, pb, 0);
        one_cycle(P, D, code2, 1'b0, 16'h0, m, hs, pb);
        chk(m == 0, {tag, " R7 second cycle uses mid-cycle level"}, m, 0);
        chk(hs == code2, {tag, " R6 second cycle high total"}, hs, code2);
        run = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(dim_out === 1'b0, {tag, " R2 output after run low"}, int'(dim_out), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(dim_out === 1'b0, "R1 output in reset", int'(dim_out), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(dim_out === 1'b0, "R1 output idle after reset", int'(dim_out), 0);

        // sweep small counter widths against every accumulator width (R9 at D=0)
        for (int p = 1; p <= 4; p++) begin
            for (int d = 0; d <= 4; d++) begin
                int mx;
                mx = (1 << (p + d)) - 1;
                run_case(p, d, 0, mx, "sweep zero/full R9 R10");
                run_case(p, d, mx, 1, "sweep full/one R10");
                run_case(p, d, 1, mx - 1, "sweep one/nearfull");
                run_case(p, d, (mx * 5) / 11, (mx * 7 + 3) & mx, "sweep mid");
            end
        end

        // explicit full-period check: base 3, fraction 3 at P=2 D=2 (R10)
        run_case(2, 2, 15, 14, "R10 full period");
        // clamp cases (R8)
        run_case(0, 7, 21, 10, "R8 pwm 0->1 dsm 7->4");
        run_case(15, 0, 3000, 77, "R8 pwm 15->12");
        run_case(3, 5, 100, 27, "R8 dsm 5->4");

        // restart mid-cycle: dropping run clears the accumulator (R2)
        @(negedge clk);
        pwm_sel = 4'd2; dsm_sel = 3'd3; level = 16'd13; run = 1'b1;
        repeat (9) @(negedge clk);
        run = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(dim_out === 1'b0, "R2 quiet after mid-cycle stop", int'(dim_out), 0);
        run_case(2, 3, 13, 13, "R2 restart fresh");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule